// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus with a 16-bit address space and the external ROM and RAM of a cartridge. A CPU write anywhere in the lower half of the address space does not reach the ROM. The block takes it as a write to one of four small control registers: a RAM gate, a primary ROM bank, a 2-bit secondary register and a mode bit. From these registers and the live CPU address it forms a physical ROM address for the two 16 KiB ROM windows and a physical RAM address for the 8 KiB RAM window at 0xA000–0xBFFF. It also builds the read data returned to the CPU. That data is the ROM byte, the RAM byte, or an open-bus value of 0xFF.

The mode bit chooses where the secondary register goes. In mode 0 (large ROM, small RAM) it only extends the switchable ROM window. The fixed window stays on bank 0 and RAM stays on bank 0. In mode 1 (small ROM, large RAM) it also relocates the fixed ROM window and selects the RAM bank. A static wiring parameter supports a multigame board on which the secondary bits sit one bit lower and the primary bank is only four bits wide. Zero substitution happens before that narrowing, so on such a board the switchable window can still reach bank 0.

Register writes take effect at the clock edge on which the write strobe is high. Addresses and read data are combinational, so a read completes in the same cycle. The CPU bus has no handshake, so the block has no valid/ready pins. Every pin is plain control or data.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the RAM gate is closed, the secondary register and mode bit are 0 and the primary bank is 1. A read at 0x4000 therefore addresses ROM byte 0x04000, and a read at 0x0000 addresses ROM byte 0.
- R2: A strobed write in 0x0000–0x1FFF opens the RAM gate when data bits 3:0 equal 0xA and closes it for any other value. Data bits 7:4 are ignored (0x1A opens the gate, 0x0B closes it).
- R3: A strobed write in 0x2000–0x3FFF loads the primary bank from data bits 4:0. A value of 0 is replaced by 1, and the result is then ANDed with 0x1F (normal wiring) or 0x0F (multigame wiring). On the multigame wiring, writing 0x10 therefore selects bank 0.
- R4: A strobed write in 0x4000–0x5FFF loads the secondary register from data bits 1:0. It supplies ROM bank bits 6:5 on normal wiring and bits 5:4 on multigame wiring.
- R5: A strobed write in 0x6000–0x7FFF loads the mode bit from data bit 0 (0 = large ROM, 1 = large RAM).
- R6: A read in 0x4000–0x7FFF addresses ROM byte bank×0x4000 + address bits 13:0, with bank = (secondary shifted to its wiring position) OR primary. The bank is reduced modulo the parameterised ROM bank count.
- R7: A read in 0x0000–0x3FFF uses ROM bank 0 in mode 0. In mode 1 it uses the shifted secondary value, reduced modulo the ROM bank count.
- R8: A RAM access at 0xA000–0xBFFF addresses RAM byte bank×0x2000 + address bits 12:0. The bank is the secondary register in mode 1 and 0 in mode 0, reduced modulo the RAM bank count.
- R9: A read in the RAM window returns 0xFF when the gate is closed or when no RAM is fitted.
- R10: A read in 0x0000–0x7FFF returns the ROM data input. A read outside the ROM and RAM windows returns 0xFF.
- R11: The RAM chip select is high only for an address in the RAM window while the gate is open and RAM is fitted. The RAM write strobe additionally needs the CPU write strobe.
- R12: The registers change only at a clock edge with the write strobe high and the address in 0x0000–0x7FFF. An unstrobed cycle or a write to the RAM window leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| rom_rdata | input | 8 | Data from the external ROM |
| ram_rdata | input | 8 | Data from the external RAM |
| rom_addr | output | log2(ROM_BANKS)+14 | Physical ROM byte address |
| ram_addr | output | max(1,log2(RAM_BANKS))+13 | Physical RAM byte address |
| ram_cs | output | 1 | RAM chip select (gated) |
| ram_we | output | 1 | RAM write strobe (gated) |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The bench builds three copies that share one bus. The first uses normal wiring with 64 ROM banks and 4 RAM banks. The second uses the multigame wiring with the same sizes. The third uses normal wiring with 32 ROM banks and no RAM. Comparing the first two on every stimulus shows the shifted secondary position and the mask-after-zero-fix rule, including bank 0 in the switchable window. The 64-bank copy shows the top secondary bit dropping out of the bank number. The 32-bank RAM-less copy exercises modulo reduction of a larger bank and the permanent open-bus RAM window.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
package cbc_pkg;

  // Mapping mode held in the mode register
  typedef enum logic {
    MAP_WIDE_ROM = 1'b0,
    MAP_WIDE_RAM = 1'b1
  } map_mode_e;

  // Register chosen by CPU address bits 14:13 during a write below 0x8000
  typedef enum logic [1:0] {
    SEL_GATE      = 2'd0,
    SEL_PRIMARY   = 2'd1,
    SEL_SECONDARY = 2'd2,
    SEL_MODE      = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       ram_gate;
    logic [4:0] primary;
    logic [1:0] secondary;
    map_mode_e  mode;
  } bank_regs_t;

  localparam logic [3:0] GATE_KEY = 4'hA;
  localparam logic [7:0] OPEN_BUS = 8'hFF;
  localparam int unsigned BANK_CALC_W = 8;

  // Zero is promoted to one before the board wiring narrows the value
  function automatic logic [4:0] fix_primary(input logic [4:0] raw,
                                             input logic [4:0] mask);
    logic [4:0] promoted;
    promoted = (raw == 5'd0) ? 5'd1 : raw;
    return promoted & mask;
  endfunction

endpackage

// File: rtl/cbc_reg_file.sv
`timescale 1ns/1ps
module cbc_reg_file
  import cbc_pkg::*;
#(
  parameter bit MULTI_WIRING = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output bank_regs_t regs_q
);

  localparam logic [4:0] PRI_MASK = MULTI_WIRING ? 5'h0F : 5'h1F;

  logic unused_ok;
  assign unused_ok = ^wdata[7:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q.ram_gate  <= 1'b0;
      regs_q.primary   <= 5'd1;
      regs_q.secondary <= 2'd0;
      regs_q.mode      <= MAP_WIDE_ROM;
    end else if (wr_en) begin
      case (reg_sel_e'(sel))
        SEL_GATE:      regs_q.ram_gate  <= (wdata[3:0] == GATE_KEY);
        SEL_PRIMARY:   regs_q.primary   <= fix_primary(wdata[4:0], PRI_MASK);
        SEL_SECONDARY: regs_q.secondary <= wdata[1:0];
        SEL_MODE:      regs_q.mode      <= map_mode_e'(wdata[0]);
        default:       regs_q.mode      <= regs_q.mode;
      endcase
    end
  end

endmodule

// File: rtl/cbc_rom_map.sv
`timescale 1ns/1ps
module cbc_rom_map
  import cbc_pkg::*;
#(
  parameter bit MULTI_WIRING = 1'b0,
  parameter int unsigned ROM_BW = 6,
  localparam int unsigned ROM_AW = ROM_BW + 14
) (
  input  bank_regs_t        regs,
  input  logic              hi_window,
  input  logic [13:0]       offset,
  output logic [ROM_AW-1:0] rom_addr
);

  logic [BANK_CALC_W-1:0] upper_bits;
  logic [BANK_CALC_W-1:0] switch_bank;
  logic [BANK_CALC_W-1:0] fixed_bank;
  logic [BANK_CALC_W-1:0] chosen_bank;

  // Board wiring decides where the secondary bits land
  generate
    if (MULTI_WIRING) begin : g_multi
      assign upper_bits = {2'b00, regs.secondary, 4'b0000};
    end else begin : g_normal
      assign upper_bits = {1'b0, regs.secondary, 5'b00000};
    end
  endgenerate

  always_comb begin
    switch_bank = upper_bits | {3'b000, regs.primary};
    fixed_bank  = (regs.mode == MAP_WIDE_RAM) ? upper_bits : '0;
    chosen_bank = hi_window ? switch_bank : fixed_bank;
  end

  // Modulo the power-of-two bank count: keep the low bank bits
  assign rom_addr = {chosen_bank[ROM_BW-1:0], offset};

  logic unused_ok;
  assign unused_ok = ^chosen_bank;

endmodule

// File: rtl/cbc_ram_map.sv
`timescale 1ns/1ps
module cbc_ram_map
  import cbc_pkg::*;
#(
  parameter int unsigned RAM_BANKS = 4,
  localparam int unsigned RAM_BW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int unsigned RAM_AW = RAM_BW + 13
) (
  input  bank_regs_t        regs,
  input  logic [12:0]       offset,
  output logic [RAM_AW-1:0] ram_addr
);

  logic [1:0]        sel_bank;
  logic [RAM_BW-1:0] fit_bank;

  assign sel_bank = (regs.mode == MAP_WIDE_RAM) ? regs.secondary : 2'b00;

  generate
    if (RAM_BANKS > 1) begin : g_banked
      assign fit_bank = sel_bank[RAM_BW-1:0];
    end else begin : g_single
      assign fit_bank = '0;
    end
  endgenerate

  assign ram_addr = {fit_bank, offset};

  logic unused_ok;
  assign unused_ok = ^{sel_bank, regs.primary, regs.ram_gate};

endmodule

// File: rtl/cart_bank_ctrl.sv
`timescale 1ns/1ps
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int unsigned ROM_BANKS    = 64,
  parameter int unsigned RAM_BANKS    = 4,
  parameter bit          MULTI_WIRING = 1'b0,
  parameter bit          RAM_FITTED   = 1'b1,
  localparam int unsigned ROM_BW = $clog2(ROM_BANKS),
  localparam int unsigned ROM_AW = ROM_BW + 14,
  localparam int unsigned RAM_BW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int unsigned RAM_AW = RAM_BW + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [7:0]        cpu_rdata
);

  bank_regs_t regs_q;
  logic       in_rom;
  logic       in_ram;
  logic       ram_gate;
  logic       ram_live;
  logic       mode_bit;

  assign in_rom   = ~cpu_addr[15];
  assign in_ram   = (cpu_addr[15:13] == 3'b101);
  assign ram_gate = regs_q.ram_gate;
  assign ram_live = ram_gate & RAM_FITTED;
  assign mode_bit = regs_q.mode;

  cbc_reg_file #(
    .MULTI_WIRING(MULTI_WIRING)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cpu_wr & in_rom),
    .sel   (cpu_addr[14:13]),
    .wdata (cpu_wdata),
    .regs_q(regs_q)
  );

  cbc_rom_map #(
    .MULTI_WIRING(MULTI_WIRING),
    .ROM_BW      (ROM_BW)
  ) u_rom_map (
    .regs     (regs_q),
    .hi_window(cpu_addr[14]),
    .offset   (cpu_addr[13:0]),
    .rom_addr (rom_addr)
  );

  cbc_ram_map #(
    .RAM_BANKS(RAM_BANKS)
  ) u_ram_map (
    .regs    (regs_q),
    .offset  (cpu_addr[12:0]),
    .ram_addr(ram_addr)
  );

  assign ram_cs = in_ram & ram_live;
  assign ram_we = ram_cs & cpu_wr;

  always_comb begin
    if (in_rom)        cpu_rdata = rom_rdata;
    else if (ram_cs)   cpu_rdata = ram_rdata;
    else               cpu_rdata = OPEN_BUS;
  end

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
`timescale 1ns/1ps
module cart_bank_ctrl_chk #(
  parameter int unsigned ROM_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_wr,
  input logic [7:0]        cpu_rdata,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              ram_we,
  input logic              ram_gate,
  input logic              ram_live,
  input logic              mode_bit
);

  AST_GATE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] == 4'hA) |=> ram_gate); // R2

  AST_MODE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=> (mode_bit == $past(cpu_wdata[0]))); // R5

  AST_ROM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> (rom_addr[13:0] == cpu_addr[13:0])); // R6

  AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00 && !mode_bit) |-> (rom_addr[ROM_AW-1:14] == '0)); // R7

  AST_OPEN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b101 && !ram_live) |-> (cpu_rdata == 8'hFF)); // R9

  AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_live && cpu_wr && cpu_addr[15:13] == 3'b101)); // R11

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(mode_bit) && $stable(ram_gate))); // R12

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_addr (cpu_addr),
  .cpu_wdata(cpu_wdata),
  .cpu_wr   (cpu_wr),
  .cpu_rdata(cpu_rdata),
  .rom_addr (rom_addr),
  .ram_we   (ram_we),
  .ram_gate (ram_gate),
  .ram_live (ram_live),
  .mode_bit (mode_bit)
);

// File: tb/cart_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic [7:0]  rom_rdata = 8'h5A;
  logic [7:0]  ram_rdata = 8'h3C;

  logic [19:0] rom_n, rom_m;
  logic [18:0] rom_r;
  logic [14:0] ram_n, ram_m;
  logic [13:0] ram_r;
  logic        cs_n, cs_m, cs_r, we_n, we_m, we_r;
  logic [7:0]  rd_n, rd_m, rd_r;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cart_bank_ctrl #(.ROM_BANKS(64), .RAM_BANKS(4), .MULTI_WIRING(1'b0), .RAM_FITTED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_addr(rom_n), .ram_addr(ram_n),
    .ram_cs(cs_n), .ram_we(we_n), .cpu_rdata(rd_n));

  cart_bank_ctrl #(.ROM_BANKS(64), .RAM_BANKS(4), .MULTI_WIRING(1'b1), .RAM_FITTED(1'b1)) dut_mg (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_addr(rom_m), .ram_addr(ram_m),
    .ram_cs(cs_m), .ram_we(we_m), .cpu_rdata(rd_m));

  cart_bank_ctrl #(.ROM_BANKS(32), .RAM_BANKS(1), .MULTI_WIRING(1'b0), .RAM_FITTED(1'b0)) dut_nr (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_addr(rom_r), .ram_addr(ram_r),
    .ram_cs(cs_r), .ram_we(we_r), .cpu_rdata(rd_r));

  typedef struct packed {
    logic [15:0] waddr;
    logic [7:0]  wdata;
    logic [15:0] raddr;
    logic [19:0] exp_n;
    logic [19:0] exp_m;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{16'h2000, 8'h05, 16'h4123, 20'h14123, 20'h14123, 8'd3},   // R3 plain value
    '{16'h2100, 8'h00, 16'h7FFF, 20'h07FFF, 20'h07FFF, 8'd3},   // R3 zero becomes one
    '{16'h3000, 8'h13, 16'h4000, 20'h4C000, 20'h0C000, 8'd3},   // R3 mask differs
    '{16'h2000, 8'h10, 16'h4010, 20'h40010, 20'h00010, 8'd3},   // R3 multigame bank 0
    '{16'h2000, 8'hE0, 16'h4001, 20'h04001, 20'h04001, 8'd3},   // R3 high bits dropped
    '{16'h4000, 8'hFE, 16'h5000, 20'h05000, 20'h85000, 8'd4},   // R4 R6 bank 65 wraps
    '{16'h5FFF, 8'h01, 16'h4002, 20'h84002, 20'h44002, 8'd4},   // R4 secondary=1
    '{16'h2000, 8'h0F, 16'h6000, 20'hBE000, 20'h7E000, 8'd6},   // R6 combined bank
    '{16'h0000, 8'h00, 16'h1234, 20'h01234, 20'h01234, 8'd7},   // R7 mode 0 fixed
    '{16'h6000, 8'h01, 16'h0234, 20'h80234, 20'h40234, 8'd7},   // R7 mode 1 relocated
    '{16'h7FFF, 8'hFE, 16'h3FFF, 20'h03FFF, 20'h03FFF, 8'd5},   // R5 bit 0 clear
    '{16'h6000, 8'h03, 16'h2000, 20'h82000, 20'h42000, 8'd5},   // R5 bit 0 set
    '{16'hA000, 8'h55, 16'h7000, 20'hBF000, 20'h7F000, 8'd12}   // R12 RAM write leaves regs
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_wr    = 1'b1;
    @(negedge clk);
    cpu_wr    = 1'b0;
  endtask

  task automatic set_read(input logic [15:0] a);
    cpu_addr = a;
    #1;
  endtask

  initial begin
    #4ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    set_read(16'h4000);
    check("R1", "reset high window", {12'h0, rom_n}, 32'h04000);
    check("R1", "reset high window mg", {12'h0, rom_m}, 32'h04000);
    set_read(16'h0000);
    check("R1", "reset low window", {12'h0, rom_n}, 32'h00000);
    @(negedge clk);
    rst_n = 1'b1;
    set_read(16'hA000);
    check("R1", "gate closed after reset", {24'h0, rd_n}, 32'hFF);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].waddr, VEC[i].wdata);
      set_read(VEC[i].raddr);
      check($sformatf("R%0d", VEC[i].tag), $sformatf("vec %0d normal", i), {12'h0, rom_n}, {12'h0, VEC[i].exp_n});
      check($sformatf("R%0d", VEC[i].tag), $sformatf("vec %0d multigame", i), {12'h0, rom_m}, {12'h0, VEC[i].exp_m});
    end

    // R6 bank 47 modulo 32 banks
    set_read(16'h4002);
    check("R6", "32-bank wrap", {13'h0, rom_r}, 32'h3C002);

    // R10 read mux
    set_read(16'h4000);
    check("R10", "rom data", {24'h0, rd_n}, 32'h5A);
    set_read(16'hC000);
    check("R10", "unmapped open bus", {24'h0, rd_n}, 32'hFF);
    set_read(16'hA000);
    check("R9", "gate closed read", {24'h0, rd_n}, 32'hFF);

    // R2 open with upper nibble set, R8 mode 1 secondary 1
    do_write(16'h0000, 8'h1A);
    set_read(16'hA123);
    check("R8", "ram addr mode1", {17'h0, ram_n}, 32'h2123);
    check("R2", "gate opened read", {24'h0, rd_n}, 32'h3C);
    check("R11", "chip select on", {31'h0, cs_n}, 32'h1);
    check("R9", "no RAM fitted", {24'h0, rd_r}, 32'hFF);

    @(negedge clk);
    cpu_addr = 16'hB000; cpu_wdata = 8'h77; cpu_wr = 1'b1;
    #1;
    check("R11", "write strobe passes", {31'h0, we_n}, 32'h1);
    check("R11", "no RAM no strobe", {31'h0, we_r}, 32'h0);
    @(negedge clk);
    cpu_wr = 1'b0;

    do_write(16'h6000, 8'h00);
    set_read(16'hA123);
    check("R8", "ram addr mode0", {17'h0, ram_n}, 32'h0123);

    do_write(16'h1FFF, 8'h0B);
    set_read(16'hA000);
    check("R2", "gate closed by 0x0B", {24'h0, rd_n}, 32'hFF);
    check("R11", "chip select off", {31'h0, cs_n}, 32'h0);
    @(negedge clk);
    cpu_wr = 1'b1;
    #1;
    check("R11", "strobe blocked", {31'h0, we_n}, 32'h0);
    @(negedge clk);
    cpu_wr = 1'b0;

    // R12 unstrobed cycle does not load primary
    @(negedge clk);
    cpu_addr = 16'h2000; cpu_wdata = 8'h07; cpu_wr = 1'b0;
    @(negedge clk);
    set_read(16'h4000);
    check("R12", "no load without strobe", {12'h0, rom_n}, 32'hBC000);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    set_read(16'h4000);
    check("R1", "mid-run reset high", {12'h0, rom_n}, 32'h04000);
    check("R1", "mid-run reset high mg", {12'h0, rom_m}, 32'h04000);
    @(negedge clk);
    rst_n = 1'b1;
    set_read(16'h0100);
    check("R1", "mid-run reset low", {12'h0, rom_n}, 32'h00100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule